// File: doc/BRIEF.md
# Asynchronous SRAM strobe sequencer

This block sits between a synchronous host and a 32K x 8 asynchronous static RAM. The host hands it one request at a time over a valid/ready channel: a read or write flag, a 15-bit word address and, for writes, a byte of data. The block turns each request into a timed sequence of the three active-low memory strobes (select, write, output enable). It also drives the address bus and controls the enable of its own data drivers. Every phase length is a whole number of clocks, computed as the ceiling of a nanosecond limit divided by the clock period.

A write presents the address and data first. The select and write strobes then fall together and stay low for the programmed pulse length. The write strobe rises one clock before the data drivers turn off, so the data hold time is met. A read holds select and output enable low for the access count, registers the bus on the last clock of that count, and then waits out the memory's bus-release time before the block may drive the bus again. Between operations the select strobe stays high, which keeps the memory in standby.

Back-pressure applies only on the request side. `req_ready` is high only while the block is idle, and a request transfers on a clock edge where `req_valid` and `req_ready` are both high. The host must hold its request fields stable until that edge. Completion is reported by a one-clock `rsp_valid` pulse that cannot be stalled, and the host must take it on the cycle it appears.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and right after reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request transfers on an edge with `req_valid`=1 and `req_ready`=1. `req_ready` stays 0 from the next cycle until the operation ends.
- R3: `mem_addr` equals the accepted address and does not change while any strobe of that operation is low.
- R4: On a write, `mem_dq_oe` is 1 and `mem_dq_out` carries the data for at least one clock before `mem_we_n` falls. The data is stable for at least 30 ns before the write ends.
- R5: On a write, `mem_ce_n` and `mem_we_n` fall together and `mem_we_n` stays 0 for exactly WE_CLKS clocks (15 at the defaults), so the memory stores the data at the accepted address.
- R6: `mem_we_n` returns to 1 one clock before `mem_dq_oe` drops. `mem_ce_n` returns to 1 in the same cycle that `mem_dq_oe` drops.
- R7: `mem_oe_n` is never 0 while `mem_we_n` is 0 or `mem_dq_oe` is 1.
- R8: On a read, `mem_ce_n` and `mem_oe_n` are 0 for RD_CLKS clocks (18 at the defaults). The bus value on the last edge of that count appears on `rsp_rdata`, with `rsp_valid`=1 for exactly one clock.
- R9: After `mem_oe_n` rises, `mem_dq_oe` stays 0 for at least TURN_CLKS+1 cycles (8 at the defaults, at least 25 ns), counting the idle cycle.
- R10: At the defaults, `rsp_valid` is 1 in the 18th cycle after the accepting edge, for both reads and writes.
- R11: `mem_ce_n` is 1 whenever `req_ready` is 1.
- R12: `rsp_rdata` keeps the last read result through later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Last read data |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable of the block's data drivers |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The hardest case to reach is bus turnaround, where a write is accepted in the first idle cycle after a read. Only then does the release window after output enable rises meet the block's own drivers. The bench reaches it by queuing requests back to back, with `req_valid` already high when `req_ready` returns. Its memory model then flags any drive inside that 25 ns window. The model also returns unknown data until 70 ns after a read starts, so sampling even one clock early shows up as a data mismatch.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WEND,
    ST_WREC,
    ST_RACC,
    ST_RREC
  } ctl_state_e;

  // Whole clocks covering a nanosecond limit.
  function automatic int clk_ceil(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CW          = 5,
  parameter int SETUP_CLKS  = 1,
  parameter int WE_CLKS     = 15,
  parameter int WREC_CLKS   = 1,
  parameter int RD_CLKS     = 18,
  parameter int TURN_CLKS   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic accept,
  output logic capture,
  output logic done,
  output logic idle,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);
  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CLKS - 1);
  localparam logic [CW-1:0] L_WE    = CW'(WE_CLKS - 1);
  localparam logic [CW-1:0] L_WEND  = '0;
  localparam logic [CW-1:0] L_WREC  = CW'(WREC_CLKS - 1);
  localparam logic [CW-1:0] L_RD    = CW'(RD_CLKS - 1);
  localparam logic [CW-1:0] L_TURN  = CW'(TURN_CLKS - 1);

  ctl_state_e    state_q, state_d;
  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_last;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    accept  = 1'b0;
    capture = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          t_load = 1'b1;
          if (req_write) begin
            state_d = ST_WSETUP;
            t_val   = L_SETUP;
          end else begin
            state_d = ST_RACC;
            t_val   = L_RD;
          end
        end
      end
      ST_WSETUP: if (t_last) begin
        state_d = ST_WPULSE;
        t_load  = 1'b1;
        t_val   = L_WE;
      end
      ST_WPULSE: if (t_last) begin
        state_d = ST_WEND;
        t_load  = 1'b1;
        t_val   = L_WEND;
      end
      ST_WEND: if (t_last) begin
        state_d = ST_WREC;
        t_load  = 1'b1;
        t_val   = L_WREC;
      end
      ST_WREC: if (t_last) begin
        state_d = ST_IDLE;
        done    = 1'b1;
      end
      ST_RACC: if (t_last) begin
        state_d = ST_RREC;
        t_load  = 1'b1;
        t_val   = L_TURN;
        capture = 1'b1;
        done    = 1'b1;
      end
      ST_RREC: if (t_last) begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Strobes decode straight from the state register.
  always_comb begin
    idle  = (state_q == ST_IDLE);
    ce_n  = !(state_q == ST_WPULSE || state_q == ST_WEND || state_q == ST_RACC);
    we_n  = !(state_q == ST_WPULSE);
    oe_n  = !(state_q == ST_RACC);
    dq_oe = (state_q == ST_WSETUP || state_q == ST_WPULSE || state_q == ST_WEND);
  end
endmodule

// File: rtl/sram_bus_path.sv
module sram_bus_path #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          done,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_valid
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= done;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_rdata  = rdata_q;
  assign rsp_valid  = rsp_q;
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int AW             = 15,
  parameter int DW             = 8,
  parameter int CLK_PERIOD_NS  = 4,
  parameter int T_CYCLE_NS     = 70,
  parameter int T_WRITE_NS     = 60,
  parameter int T_ACCESS_NS    = 70,
  parameter int T_RELEASE_NS   = 25,
  parameter int SETUP_CLKS     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int CYC_CLKS  = clk_ceil(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int WE_CLKS   = clk_ceil(T_WRITE_NS, CLK_PERIOD_NS);
  localparam int RD_CLKS   = clk_ceil(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int TURN_CLKS = max2(1, clk_ceil(T_RELEASE_NS, CLK_PERIOD_NS));
  localparam int WUSED     = SETUP_CLKS + WE_CLKS + 1;
  localparam int WREC_CLKS = (CYC_CLKS > WUSED) ? (CYC_CLKS - WUSED) : 1;
  localparam int MAXC      = max2(max2(WE_CLKS, RD_CLKS), max2(TURN_CLKS, max2(WREC_CLKS, SETUP_CLKS)));
  localparam int CW        = $clog2(MAXC + 1);

  logic accept, capture, done, idle;

  sram_seq_fsm #(
    .CW         (CW),
    .SETUP_CLKS (SETUP_CLKS),
    .WE_CLKS    (WE_CLKS),
    .WREC_CLKS  (WREC_CLKS),
    .RD_CLKS    (RD_CLKS),
    .TURN_CLKS  (TURN_CLKS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .accept    (accept),
    .capture   (capture),
    .done      (done),
    .idle      (idle),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .dq_oe     (mem_dq_oe)
  );

  sram_bus_path #(.AW(AW), .DW(DW)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .done       (done),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_rdata  (rsp_rdata),
    .rsp_valid  (rsp_valid)
  );

  assign req_ready = idle;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int WE_CLKS   = 15,
  parameter int TURN_CLKS = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe
);
  localparam int SAT = TURN_CLKS + 2;
  logic [15:0] we_low_cnt;
  logic [15:0] oe_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_low_cnt <= '0;
    else if (mem_we_n) we_low_cnt <= '0;
    else we_low_cnt <= we_low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_high_cnt <= 16'(SAT);
    else if (!mem_oe_n) oe_high_cnt <= '0;
    else if (oe_high_cnt < 16'(SAT)) oe_high_cnt <= oe_high_cnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R11
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe)); // R7
  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_dq_oe)); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr)); // R3
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(mem_dq_oe) && $stable(mem_dq_out))); // R4
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 16'(WE_CLKS))); // R5
  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> (mem_we_n && $past(mem_we_n) && mem_ce_n)); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_high_cnt > 16'(TURN_CLKS))); // R9
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .AW(AW), .DW(DW), .WE_CLKS(WE_CLKS), .TURN_CLKS(TURN_CLKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_dq_out (mem_dq_out),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;
  localparam int LAT  = 18;
  localparam int WEC  = 15;
  localparam int TURN = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] dq_model = 8'hzz;
  logic [14:0] mem_addr;

  always #2 clk = ~clk;

  sram_strobe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_model)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done_flag = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: select/write overlap rule, access delay, release window.
  logic [7:0] mem_model [int unsigned];
  logic [7:0] ref_mem   [int unsigned];
  bit     wact_p = 0, rd_p = 0, oe_p = 1;
  logic [7:0]  w_data;
  logic [14:0] w_addr;
  longint w_stable_t = 0, rd_t = 0, oe_rise_t = -1000;

  always @(negedge clk) begin
    bit wact, rd;
    wact = !mem_ce_n && !mem_we_n;
    rd   = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (mem_oe_n && !oe_p) oe_rise_t = $time - 2;
    if (wact) begin
      if (!wact_p) begin
        w_data = mem_dq_out; w_addr = mem_addr; w_stable_t = $time;
      end else begin
        if (mem_dq_out !== w_data) begin w_data = mem_dq_out; w_stable_t = $time; end
        if (mem_addr !== w_addr) check(0, "R3 addr moved in write", mem_addr, w_addr);
      end
      if (!mem_dq_oe) check(0, "R4 undriven write", 0, 1);
    end else if (wact_p) begin
      check(($time - w_stable_t) >= 30, "R4 data setup ns", $time - w_stable_t, 30);
      mem_model[w_addr] = w_data;
    end
    if (mem_dq_oe && (rd || ($time - 2 - oe_rise_t) < 25))
      check(0, "R9 bus contention", $time - 2 - oe_rise_t, 25);
    if (rd) begin
      if (!rd_p) rd_t = $time - 2;
      dq_model = (($time - rd_t) >= 70 && mem_model.exists(mem_addr)) ? mem_model[mem_addr] : 8'hxx;
    end else begin
      dq_model = 8'hzz;
    end
    wact_p = wact; rd_p = rd; oe_p = mem_oe_n;
  end

  // Strobe-order observer.
  int we_low = 0, oe_high = 100;
  logic we_p = 1, dqoe_p = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n && we_p) check(dqoe_p, "R4 data before we fall", dqoe_p, 1);
      if (mem_we_n && !we_p) check(we_low == WEC, "R5 we low clocks", we_low, WEC);
      if (!mem_dq_oe && dqoe_p) check(mem_we_n && we_p && mem_ce_n, "R6 release order", {we_p, mem_ce_n}, 2'b11);
      if (mem_dq_oe && !dqoe_p) check(oe_high >= TURN + 1, "R9 turnaround clocks", oe_high, TURN + 1);
      if (req_ready && !mem_ce_n) check(0, "R11 standby", mem_ce_n, 1);
    end
    we_low  = mem_we_n ? 0 : we_low + 1;
    oe_high = mem_oe_n ? oe_high + 1 : 0;
    we_p = mem_we_n; dqoe_p = mem_dq_oe;
  end

  // Scoreboard.
  typedef struct { bit rd; logic [14:0] addr; logic [7:0] data; int t_acc; } item_t;
  item_t q[$];
  logic [7:0] last_rd = 8'h00;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) check(0, "R8 unexpected rsp", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        check(cyc - it.t_acc == LAT, "R10 latency", cyc - it.t_acc, LAT);
        if (it.rd) begin
          check(rsp_rdata === it.data, "R8 read data", rsp_rdata, it.data);
          last_rd = it.data;
        end else begin
          check(mem_model.exists(it.addr) && mem_model[it.addr] === it.data, "R5 stored byte",
                mem_model.exists(it.addr) ? mem_model[it.addr] : 8'hxx, it.data);
          check(rsp_rdata === last_rd, "R12 rdata kept", rsp_rdata, last_rd);
        end
      end
    end
  end

  task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    it.rd = !wr; it.addr = a; it.t_acc = cyc;
    if (wr) begin ref_mem[a] = d; it.data = d; end
    else it.data = ref_mem[a];
    q.push_back(it);
    req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    check(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    logic [14:0] la;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
          "R1 in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);
    rst_n = 1;
    @(negedge clk);
    check(mem_ce_n && req_ready && !rsp_valid, "R1 after reset", {mem_ce_n, req_ready}, 2'b11);

    do_op(1, 15'h0000, 8'hA5);
    @(negedge clk); @(negedge clk);
    check(!req_ready, "R2 busy ready", req_ready, 0);
    check(mem_addr == 15'h0000, "R3 address", mem_addr, 0);
    drain();
    do_op(1, 15'h7FFF, 8'h5A);
    do_op(1, 15'h1234, 8'hFF);
    do_op(1, 15'h2AAA, 8'h00);
    do_op(0, 15'h0000, 8'h00);
    do_op(0, 15'h7FFF, 8'h00);
    do_op(1, 15'h4321, 8'h3C);   // write straight after read: turnaround R9
    do_op(0, 15'h1234, 8'h00);
    do_op(0, 15'h2AAA, 8'h00);
    do_op(1, 15'h1234, 8'h81);   // overwrite
    do_op(0, 15'h1234, 8'h00);
    do_op(0, 15'h4321, 8'h00);
    la = 15'h0101;
    for (int i = 0; i < 12; i++) begin
      la = {la[13:0], la[14] ^ la[13]};
      do_op(1, la, 8'(la ^ 15'(i * 37)));
      do_op(0, la, 8'h00);
    end
    drain();
    repeat (4) @(negedge clk);
    check(req_ready && mem_ce_n, "R11 idle standby", {req_ready, mem_ce_n}, 2'b11);
    report();
  end
endmodule